// File: doc/BRIEF.md
# Three-Slot Fresh-Frame Exchange Buffer

This block hands whole data frames from a producer to a consumer without either side ever stalling on the other. The producer may complete frames faster than they are taken, so unread frames are overwritten. The consumer may ask more often than frames arrive, so the same frame is handed out again. A consumer always gets the most recently completed frame, and never a frame that is only partly stored.

Three frame slots are steered by three slot indices. `newIdx` is the slot the next frame goes into. `lastIdx` is the slot of the newest complete frame. `readIdx` is the slot the consumer is reading. A write stores the frame into `newIdx` and then copies `newIdx` into `lastIdx`. It then moves `newIdx` to a slot that is neither `lastIdx` nor `readIdx`. A read copies `lastIdx` into `readIdx` and then presents that slot's frame. The two steps that touch the indices shared between the sides are serialised by a small arbiter.

Each side has a start pulse and a done pulse. Two extra pulses, returned with the done pulses, report a frame that was overwritten unread and a frame that was handed out a second time.

Top module: `slot3_exchange`

## Requirements
- R1: While `rstN` is low and after its release, `wrDone`, `rdDone`, `wrSkip`, `rdOld` and `rdData` are 0. All slots hold 0. The indices reset to new=0, last=1, read=1, so a read before any write returns 0 with `rdOld` set.
- R2: When `wrStart` is sampled high by an idle producer side, the frame on `wrData` is stored in that same edge. If the arbiter is uncontested, `wrDone` is high during the cycle after the second following clock edge.
- R3: A read returns the frame of the newest write whose `wrDone` was seen before `rdStart` was raised, or a newer completed frame.
- R4: When `rdStart` is sampled high by an idle consumer side and the arbiter is uncontested, `rdDone` and the valid `rdData` appear during the cycle after the second following clock edge. `rdData` holds its value until the next read completes.
- R5: The producer's index update and the consumer's index capture never happen in the same cycle. When both request in the same cycle, the producer is served first and the consumer one cycle later. In the case where both start together, the read returns the new frame and its `rdDone` comes one cycle later than in R4.
- R6: `wrSkip` is high together with `wrDone` exactly when the previously completed frame had not been captured by any read.
- R7: `rdOld` is high together with `rdDone` exactly when the captured frame had already been captured by an earlier read, or is the reset frame.
- R8: A `wrStart` or `rdStart` that arrives while its side is still busy is ignored. It stores nothing and produces no extra done pulse.
- R9: Coherence: the slot being filled is never the slot being read, and every read returns a whole frame exactly as it was written.
- R10: `wrDone` and `rdDone` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | Producer start pulse; frame sampled with it |
| wrData | input | DATA_W | Frame to store |
| wrDone | output | 1 | Producer operation complete (one cycle) |
| wrSkip | output | 1 | Previous complete frame was never read |
| rdStart | input | 1 | Consumer start pulse |
| rdData | output | DATA_W | Frame delivered by the last completed read |
| rdDone | output | 1 | Consumer operation complete (one cycle) |
| rdOld | output | 1 | Delivered frame had already been delivered |

## Verification
The assertions assume that each side raises its start pulse only when that side is idle, and holds it for a single cycle. The index properties also assume that the indices start from the reset values, which are three distinct-or-equal legal slot numbers. The stimulus meets this by issuing a new start only after the matching done pulse. The one exception is the deliberate busy-start case, which the RTL must ignore and which no assertion relies on. In the random phase the producer and the consumer run concurrently with independent random gaps, so both the contested and the uncontested arbiter paths are reached.

// File: rtl/slot3_pkg.sv
package slot3_pkg;
  localparam int NUM_SLOTS = 3;
  localparam int IDX_W = $clog2(NUM_SLOTS);

  typedef logic [IDX_W-1:0] slotIdx_t;

  // strobes from control to datapath, one per control statement
  typedef struct packed {
    logic storeNew;  // write frame into slot newIdx
    logic setLast;   // lastIdx <= newIdx
    logic setNew;    // newIdx  <= free slot
    logic setRead;   // readIdx <= lastIdx
    logic loadOut;   // rdData  <= slot readIdx
  } slotStrb_t;

  // lowest slot number equal to neither argument
  function automatic slotIdx_t pickFree(slotIdx_t a, slotIdx_t b);
    slotIdx_t res;
    logic found;
    res = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!found && slotIdx_t'(i) != a && slotIdx_t'(i) != b) begin
        res = slotIdx_t'(i);
        found = 1'b1;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/slot3_datapath.sv
module slot3_datapath
  import slot3_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  slotIdx_t newIdx, lastIdx, readIdx;
  logic [DATA_W-1:0] slotMem [NUM_SLOTS];

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) slotMem[g] <= '0;
        else if (strb.storeNew && newIdx == slotIdx_t'(g)) slotMem[g] <= wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newIdx  <= slotIdx_t'(0);
      lastIdx <= slotIdx_t'(1);
      readIdx <= slotIdx_t'(1);
    end else begin
      if (strb.setLast) lastIdx <= newIdx;
      if (strb.setNew)  newIdx  <= pickFree(lastIdx, readIdx);
      if (strb.setRead) readIdx <= lastIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.loadOut) rdData <= slotMem[readIdx];
  end

  // R9
  newNotRead_chk: assert property (@(posedge clk) disable iff (!rstN)
    newIdx != readIdx);
  // R9
  idxLegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (newIdx < NUM_SLOTS) && (lastIdx < NUM_SLOTS) && (readIdx < NUM_SLOTS));
  // R3
  readTakesLast_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRead |=> readIdx == $past(lastIdx));
  // R9
  newLeavesLast_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setNew |=> newIdx != lastIdx);
endmodule

// File: rtl/slot3_ctrl.sv
module slot3_ctrl
  import slot3_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStart,
  input  logic      rdStart,
  output slotStrb_t strb,
  output logic      wrDone,
  output logic      wrSkip,
  output logic      rdDone,
  output logic      rdOld
);
  typedef enum logic [1:0] {W_IDLE, W_ARB, W_SET} wrState_t;
  typedef enum logic [1:0] {R_IDLE, R_ARB, R_OUT} rdState_t;

  wrState_t wrState;
  rdState_t rdState;
  logic wReq, rReq, gntW, gntR;
  logic unread, skipHold, oldHold;

  // arbiter over the shared-index steps; producer wins a tie
  assign wReq = (wrState == W_ARB);
  assign rReq = (rdState == R_ARB);
  assign gntW = wReq;
  assign gntR = rReq && !wReq;

  always_comb begin
    strb = '0;
    strb.storeNew = (wrState == W_IDLE) && wrStart;
    strb.setLast  = gntW;
    strb.setNew   = (wrState == W_SET);
    strb.setRead  = gntR;
    strb.loadOut  = (rdState == R_OUT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrState  <= W_IDLE;
      rdState  <= R_IDLE;
      unread   <= 1'b0;
      skipHold <= 1'b0;
      oldHold  <= 1'b0;
      wrDone   <= 1'b0;
      wrSkip   <= 1'b0;
      rdDone   <= 1'b0;
      rdOld    <= 1'b0;
    end else begin
      wrDone <= 1'b0;
      wrSkip <= 1'b0;
      rdDone <= 1'b0;
      rdOld  <= 1'b0;
      case (wrState)
        W_IDLE: if (wrStart) wrState <= W_ARB;
        W_ARB: if (gntW) begin
          skipHold <= unread;
          unread   <= 1'b1;
          wrState  <= W_SET;
        end
        W_SET: begin
          wrDone  <= 1'b1;
          wrSkip  <= skipHold;
          wrState <= W_IDLE;
        end
        default: wrState <= W_IDLE;
      endcase
      case (rdState)
        R_IDLE: if (rdStart) rdState <= R_ARB;
        R_ARB: if (gntR) begin
          oldHold <= !unread;
          unread  <= 1'b0;
          rdState <= R_OUT;
        end
        R_OUT: begin
          rdDone  <= 1'b1;
          rdOld   <= oldHold;
          rdState <= R_IDLE;
        end
        default: rdState <= R_IDLE;
      endcase
    end
  end

  // R5
  sharedMutex_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setLast && strb.setRead));
  // R5
  readerWaitsOne_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rReq && !gntR) |=> strb.setRead);
  // R2
  newAfterLast_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setNew |-> $past(strb.setLast));
  // R10
  wrDonePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone);
  // R10
  rdDonePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |=> !rdDone);
  // R6
  skipWithDone_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSkip |-> wrDone);
  // R7
  oldWithDone_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdOld |-> rdDone);
endmodule

// File: rtl/slot3_exchange.sv
module slot3_exchange
  import slot3_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrDone,
  output logic              wrSkip,
  input  logic              rdStart,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone,
  output logic              rdOld
);
  slotStrb_t strb;

  slot3_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .rdStart(rdStart),
    .strb(strb), .wrDone(wrDone), .wrSkip(wrSkip),
    .rdDone(rdDone), .rdOld(rdOld)
  );

  slot3_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/slot3_exchange_tb.sv
module slot3_exchange_tb;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStart = 1'b0;
  logic rdStart = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic wrDone, wrSkip, rdDone, rdOld;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastDoneSeq = 0;
  int lastStartSeq = 0;

  always #10 clk = ~clk;

  slot3_exchange #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrData(wrData),
    .wrDone(wrDone), .wrSkip(wrSkip), .rdStart(rdStart),
    .rdData(rdData), .rdDone(rdDone), .rdOld(rdOld)
  );

  function automatic logic [DATA_W-1:0] mkFrame(int seq);
    logic [31:0] h;
    h = seq * 40503;
    return {seq[15:0], h[15:0] ^ 16'h5A5A};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic doWrite(input int seq, output logic skip);
    int n;
    @(negedge clk); wrStart = 1'b1; wrData = mkFrame(seq);
    lastStartSeq = seq;
    @(negedge clk); wrStart = 1'b0;
    n = 0;
    while (!wrDone && n < 20) begin @(negedge clk); n++; end
    check(wrDone, "R2 write done", wrDone, 1);
    skip = wrSkip;
    lastDoneSeq = seq;
  endtask

  task automatic doRead(output logic [DATA_W-1:0] val, output logic old,
                        output int floorSeq);
    int n;
    @(negedge clk); rdStart = 1'b1;
    floorSeq = lastDoneSeq;
    @(negedge clk); rdStart = 1'b0;
    n = 0;
    while (!rdDone && n < 20) begin @(negedge clk); n++; end
    check(rdDone, "R4 read done", rdDone, 1);
    val = rdData;
    old = rdOld;
  endtask

  initial begin
    logic sk, od;
    logic [DATA_W-1:0] v;
    int fl;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!wrDone && !rdDone && !wrSkip && !rdOld, "R1 flags in reset",
          {wrDone, rdDone, wrSkip, rdOld}, 0);
    check(rdData == 0, "R1 rdData in reset", rdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == 0 && !wrDone && !rdDone, "R1 after release", rdData, 0);

    // R1 R7 read before any write
    doRead(v, od, fl);
    check(v == 0, "R1 reset frame read", v, 0);
    check(od == 1'b1, "R7 reset frame is old", od, 1);

    // R2 exact write timing
    @(negedge clk); wrStart = 1'b1; wrData = mkFrame(1); lastStartSeq = 1;
    @(negedge clk); wrStart = 1'b0;
    check(!wrDone, "R2 no done after first edge", wrDone, 0);
    @(negedge clk);
    check(!wrDone, "R2 no done after second edge", wrDone, 0);
    @(negedge clk);
    check(wrDone, "R2 done on time", wrDone, 1);
    check(!wrSkip, "R6 no skip over read frame", wrSkip, 0);
    lastDoneSeq = 1;
    @(negedge clk);
    check(!wrDone, "R10 write done one cycle", wrDone, 0);

    // R4 exact read timing, R3 freshness
    @(negedge clk); rdStart = 1'b1;
    @(negedge clk); rdStart = 1'b0;
    @(negedge clk);
    check(!rdDone, "R4 no done early", rdDone, 0);
    @(negedge clk);
    check(rdDone, "R4 done on time", rdDone, 1);
    check(rdData == mkFrame(1), "R3 read newest", rdData, mkFrame(1));
    check(!rdOld, "R7 fresh read not old", rdOld, 0);
    @(negedge clk);
    check(!rdDone, "R10 read done one cycle", rdDone, 0);
    check(rdData == mkFrame(1), "R4 rdData holds", rdData, mkFrame(1));

    // R7 re-read
    doRead(v, od, fl);
    check(v == mkFrame(1), "R3 re-read value", v, mkFrame(1));
    check(od == 1'b1, "R7 re-read flagged old", od, 1);

    // R6 overwrite unread
    doWrite(2, sk);
    check(sk == 1'b0, "R6 first write no skip", sk, 0);
    doWrite(3, sk);
    check(sk == 1'b1, "R6 overwrite flagged", sk, 1);
    doRead(v, od, fl);
    check(v == mkFrame(3), "R3 newest after overwrite", v, mkFrame(3));
    check(od == 1'b0, "R7 new frame not old", od, 0);

    // R5 simultaneous start
    @(negedge clk); wrStart = 1'b1; rdStart = 1'b1; wrData = mkFrame(4);
    lastStartSeq = 4;
    @(negedge clk); wrStart = 1'b0; rdStart = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(wrDone && !rdDone, "R5 writer first", {wrDone, rdDone}, 2'b10);
    lastDoneSeq = 4;
    @(negedge clk);
    check(rdDone, "R5 reader one cycle later", rdDone, 1);
    check(rdData == mkFrame(4), "R5 reader gets new frame", rdData, mkFrame(4));
    check(!rdOld, "R7 contested read not old", rdOld, 0);

    // R8 start while busy ignored
    @(negedge clk); wrStart = 1'b1; wrData = mkFrame(5); lastStartSeq = 5;
    @(negedge clk); wrData = mkFrame(999);
    @(negedge clk); wrStart = 1'b0;
    @(negedge clk);
    check(wrDone, "R8 single write completes", wrDone, 1);
    lastDoneSeq = 5;
    @(negedge clk);
    check(!wrDone, "R8 no extra done", wrDone, 0);
    @(negedge clk);
    check(!wrDone, "R8 no extra done later", wrDone, 0);
    doRead(v, od, fl);
    check(v == mkFrame(5), "R8 busy start stored nothing", v, mkFrame(5));

    // random concurrent phase: R3 R9
    fork
      begin
        for (int s = 6; s < 306; s++) begin
          repeat ($urandom_range(0, 6)) @(negedge clk);
          doWrite(s, sk);
        end
      end
      begin
        for (int k = 0; k < 300; k++) begin
          int sq;
          repeat ($urandom_range(0, 6)) @(negedge clk);
          doRead(v, od, fl);
          sq = int'(v[DATA_W-1:16]);
          check(v == mkFrame(sq), "R9 whole frame", v, mkFrame(sq));
          check(sq >= fl && sq <= lastStartSeq, "R3 fresh frame", sq, fl);
        end
      end
    join

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule